// File: doc/BRIEF.md
# Multi-Bank Lane Scratchpad with Conflict Replay

This block is an on-chip scratchpad that serves one warp-wide request at a time. Each of the 32 lanes brings a word address, an active bit and write data. A single read/write flag applies to every lane. Storage is split into independent single-port banks. Each lane is steered to the bank chosen by the low bits of its address. In every cycle each bank serves exactly one distinct word.

Lanes that meet in a bank with different addresses are replayed over further cycles until all active lanes are served. Lanes that carry the very same address are merged into one access. On a read, that access's data is broadcast to all of the merged lanes.

Requests enter through a valid/ready handshake. Read results come back as one wide per-lane vector together with a single-cycle completion pulse.

Top module: `scp_top`

## Requirements
- R1: With 32 banks, a lane's bank is bits [4:0] of its word address, and its row inside the bank is the bits above them. Two lanes whose addresses differ only above bit 4 use the same bank.
- R2: `req_ready` is 1 after reset and whenever the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle on, `req_ready` stays 0 and rises again only in the cycle that `rsp_done` is 1.
- R3: If every active lane maps to a different bank, `rsp_done` is 1 in the second cycle after the accepting edge.
- R4: Let N be the largest number of distinct active addresses that fall in any one bank, with N taken as 1 when no lane is active. Then `rsp_done` is 1 exactly N+1 cycles after the accepting edge.
- R5: Active lanes that share one exact address use a single access in their bank and add nothing to N. On a read, all of them receive the same word.
- R6: When several active lanes of one write request target the same address, the word stored there is the write data of the highest-numbered of those lanes.
- R7: After a read completes, slot k of `rsp_rdata` (bits k*32 .. k*32+31) holds the stored word at lane k's address for every active lane k. Slots of inactive lanes keep their previous contents. After a write request, every slot keeps its previous contents.
- R8: `rsp_done` is high for exactly one cycle per accepted request. `rsp_rdata` does not change while `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write for all lanes, 0 = read |
| lane_active | input | 32 | Per-lane active bit |
| lane_addr | input | 320 | Word address, 10 bits per lane, lane k at k*10 |
| lane_wdata | input | 1024 | Write data, 32 bits per lane, lane k at k*32 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1024 | Per-lane read results, lane k at k*32 |

## Verification
Two things can happen in the same replay cycle: a bank serializes lanes with different addresses, and lanes that share an address in that bank are merged. A mixed pattern provokes this: half the lanes read one address of a bank, and the other half read a second address of the same bank. The result is judged by a completion exactly three cycles after acceptance, with each half receiving its own word.

A second overlap comes from a write in which all lanes hit one address, followed by a read of that address. That read must return the top lane's data after the broadcast-minimum latency. A scoreboard driven from a behavioural memory model checks both the data and the cycle count of every request, and it also checks randomized address patterns.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int unsigned LANES_DEF = 32;
    localparam int unsigned BANKS_DEF = 32;
    localparam int unsigned AW_DEF    = 10;
    localparam int unsigned DW_DEF    = 32;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_REPLAY = 2'd1,
        PH_DRAIN  = 2'd2
    } scp_phase_e;
endpackage

// File: rtl/scp_bank.sv
module scp_bank #(
    parameter int unsigned ROWS = 32,
    parameter int unsigned RW   = 5,
    parameter int unsigned DW   = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[row] <= wdata;
            end else begin
                rdata <= mem_q[row];
            end
        end
    end
endmodule

// File: rtl/scp_sched.sv
module scp_sched #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 32,
    localparam int unsigned BBITS = $clog2(BANKS),
    localparam int unsigned RW    = AW - BBITS
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr,
    input  logic [LANES*DW-1:0] wdat,
    output logic [LANES-1:0]    grant,
    output logic [BANKS-1:0]    bank_hit,
    output logic [BANKS*RW-1:0] bank_row,
    output logic [BANKS*DW-1:0] bank_wdata
);
    logic [AW-1:0]    win_addr [BANKS];
    logic [BBITS-1:0] lane_bank [LANES];

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_bank[l] = addr[l*AW +: BBITS];
        end
    end

    // lowest pending lane in each bank picks the address served this cycle
    always_comb begin
        bank_hit = '0;
        for (int b = 0; b < BANKS; b++) begin
            win_addr[b] = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pend[l] && lane_bank[l] == BBITS'(b)) begin
                    bank_hit[b] = 1'b1;
                    win_addr[b] = addr[l*AW +: AW];
                end
            end
        end
    end

    // every pending lane matching its bank's chosen address retires together
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            grant[l] = pend[l] && (win_addr[lane_bank[l]] == addr[l*AW +: AW]);
        end
    end

    // row select and write data: highest granted lane of the bank wins
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_row[b*RW +: RW]   = win_addr[b][AW-1:BBITS];
            bank_wdata[b*DW +: DW] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (grant[l] && lane_bank[l] == BBITS'(b)) begin
                    bank_wdata[b*DW +: DW] = wdat[l*DW +: DW];
                end
            end
        end
    end
endmodule

// File: rtl/scp_top.sv
module scp_top
    import scp_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned BANKS = BANKS_DEF,
    parameter int unsigned AW    = AW_DEF,
    parameter int unsigned DW    = DW_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LANES-1:0]    lane_active,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                rsp_done,
    output logic [LANES*DW-1:0] rsp_rdata
);
    localparam int unsigned BBITS = $clog2(BANKS);
    localparam int unsigned RW    = AW - BBITS;
    localparam int unsigned ROWS  = 2 ** RW;

    typedef struct packed {
        scp_phase_e          ph;
        logic                wr;
        logic [LANES-1:0]    pend;
        logic [LANES-1:0]    cap;
        logic                done;
        logic [LANES*AW-1:0] addr;
        logic [LANES*DW-1:0] wdat;
        logic [LANES*DW-1:0] res;
    } scp_state_t;

    scp_state_t st_d, st_q;

    logic [LANES-1:0]    grant_w;
    logic [BANKS-1:0]    bank_hit;
    logic [BANKS-1:0]    bank_en;
    logic [BANKS*RW-1:0] bank_row;
    logic [BANKS*DW-1:0] bank_wdata;
    logic [BANKS*DW-1:0] bank_rdata;
    logic                replay_w;

    assign replay_w = (st_q.ph == PH_REPLAY);
    assign bank_en  = replay_w ? bank_hit : '0;

    scp_sched #(
        .LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)
    ) u_sched (
        .pend       (st_q.pend),
        .addr       (st_q.addr),
        .wdat       (st_q.wdat),
        .grant      (grant_w),
        .bank_hit   (bank_hit),
        .bank_row   (bank_row),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        scp_bank #(
            .ROWS(ROWS), .RW(RW), .DW(DW)
        ) u_bank (
            .clk   (clk),
            .en    (bank_en[b]),
            .we    (st_q.wr),
            .row   (bank_row[b*RW +: RW]),
            .wdata (bank_wdata[b*DW +: DW]),
            .rdata (bank_rdata[b*DW +: DW])
        );
    end

    always_comb begin
        logic [BBITS-1:0] bsel;
        logic [LANES-1:0] left;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.cap  = '0;
        left      = st_q.pend & ~grant_w;

        // lanes read in the previous cycle pick up their bank's registered word
        for (int l = 0; l < LANES; l++) begin
            bsel = st_q.addr[l*AW +: BBITS];
            if (st_q.cap[l]) begin
                st_d.res[l*DW +: DW] = bank_rdata[int'(bsel)*DW +: DW];
            end
        end

        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph   = PH_REPLAY;
                    st_d.wr   = req_write;
                    st_d.pend = lane_active;
                    st_d.addr = lane_addr;
                    st_d.wdat = lane_wdata;
                end
            end
            PH_REPLAY: begin
                st_d.pend = left;
                st_d.cap  = st_q.wr ? '0 : grant_w;
                if (left == '0) begin
                    st_d.ph = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign rsp_done  = st_q.done;
    assign rsp_rdata = st_q.res;
endmodule

// File: rtl/scp_top_chk.sv
module scp_top_chk #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DW    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_done,
    input logic [LANES*DW-1:0] rsp_rdata,
    input logic                in_replay,
    input logic [LANES-1:0]    pend,
    input logic [LANES-1:0]    grant
);
    AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_READY_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> rsp_done); // R2
    AST_DONE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_RESULTS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> $stable(rsp_rdata)); // R8
    AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R4
    AST_REPLAY_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_replay && pend != '0) |-> grant != '0); // R4
endmodule

bind scp_top scp_top_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .in_replay (replay_w),
    .pend      (st_q.pend),
    .grant     (grant_w)
);

// File: tb/scp_top_test.sv
module scp_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 2 ** AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [LANES-1:0]    lane_active = '0;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [LANES*DW-1:0] lane_wdata = '0;
    logic                rsp_done;
    logic [LANES*DW-1:0] rsp_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scp_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .lane_active(lane_active), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        int                  acc;
        int                  lat;
        logic [LANES*DW-1:0] res;
        string               tag;
    } exp_t;

    exp_t             sb_q[$];
    int               n_cmp = 0;
    int               n_bad = 0;
    int               cyc = 0;
    int               n_done = 0;
    logic [DW-1:0]    model [WORDS];
    logic [LANES*DW-1:0] exp_res = '0;
    logic [AW-1:0]    ta [LANES];
    logic [DW-1:0]    td [LANES];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: builds the expected item from the model, then offers the request
    task automatic do_req(input bit wr, input logic [LANES-1:0] act, input string tag);
        exp_t it;
        int   cnt [BANKS];
        int   n;
        bit   seen;
        for (int b = 0; b < BANKS; b++) cnt[b] = 0;
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
                seen = 0;
                for (int j = 0; j < l; j++)
                    if (act[j] && ta[j] == ta[l]) seen = 1;
                if (!seen) cnt[ta[l] % BANKS]++;
            end
        end
        n = 1;
        for (int b = 0; b < BANKS; b++) if (cnt[b] > n) n = cnt[b];
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
                if (wr) model[ta[l]] = td[l];
                else exp_res[l*DW +: DW] = model[ta[l]];
            end
        end
        it.lat = n + 1;
        it.res = exp_res;
        it.tag = tag;
        @(negedge clk);
        req_valid   = 1'b1;
        req_write   = wr;
        lane_active = act;
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*AW +: AW]  = ta[l];
            lane_wdata[l*DW +: DW] = td[l];
        end
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        it.acc    = cyc;
        req_valid = 1'b0;
        sb_q.push_back(it);
        chk(req_ready == 1'b0, {"R2 ready low after accept ", tag}, 64'(req_ready), 64'd0);
    endtask

    // monitor: pops one expected item per completion
    initial begin
        bit follow = 0;
        logic [LANES*DW-1:0] held = '0;
        forever begin
            @(negedge clk);
            if (follow) begin
                follow = 0;
                chk(rsp_done == 1'b0, "R8 done lasts one cycle", 64'(rsp_done), 64'd0);
                chk(rsp_rdata == held, "R8 results held after done",
                    64'(rsp_rdata[63:0]), 64'(held[63:0]));
            end
            if (rst_n && rsp_done) begin
                exp_t it;
                int   bad;
                n_done++;
                if (sb_q.size() == 0) begin
                    chk(0, "R8 done with no request outstanding", 64'd1, 64'd0);
                end else begin
                    it = sb_q.pop_front();
                    chk(cyc - it.acc == it.lat, {"R3/R4 latency ", it.tag},
                        64'(cyc - it.acc), 64'(it.lat));
                    bad = -1;
                    for (int l = 0; l < LANES; l++)
                        if (bad < 0 && rsp_rdata[l*DW +: DW] !== it.res[l*DW +: DW]) bad = l;
                    if (bad < 0) chk(1, "R7 data", 64'd0, 64'd0);
                    else chk(0, {"R7 data lane mismatch ", it.tag},
                             64'(rsp_rdata[bad*DW +: DW]), 64'(it.res[bad*DW +: DW]));
                    chk(req_ready == 1'b1, "R2 ready back with done", 64'(req_ready), 64'd1);
                    held   = rsp_rdata;
                    follow = 1;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_done == 1'b0, "R8 no done after reset", 64'(rsp_done), 64'd0);

        // fill every word: conflict-free writes (R3)
        for (int k = 0; k < WORDS / LANES; k++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l] = AW'(k * LANES + l);
                td[l] = 32'hA5000000 ^ (32'(k) << 12) ^ (32'(l) * 32'h9E37);
            end
            do_req(1, '1, "R3 fill write");
        end

        // one lane per bank, rotating rows (R1, R3)
        for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 33);
        do_req(0, '1, "R1 R3 spread read");

        // every lane in bank 0, distinct rows (R4)
        for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 32);
        do_req(0, '1, "R4 32-way conflict");

        // all lanes on one word (R5)
        for (int l = 0; l < LANES; l++) ta[l] = AW'(77);
        do_req(0, '1, "R5 broadcast");

        // bank 5 with two addresses, half each (R1 R4 R5)
        for (int l = 0; l < LANES; l++) ta[l] = (l < 16) ? AW'(5) : AW'(37);
        do_req(0, '1, "R1 R5 two-address bank");

        // everyone writes one word; top lane must win (R6)
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(200);
            td[l] = 32'h1000 + 32'(l);
        end
        do_req(1, '1, "R6 same-address write");
        do_req(0, 32'h0000_0001, "R6 readback");

        // even lanes only; odd slots keep old data (R7)
        for (int l = 0; l < LANES; l++) ta[l] = AW'(l * 7 + 3);
        do_req(0, 32'h5555_5555, "R7 partial read");

        // no active lanes (R4)
        do_req(0, '0, "R4 empty request");

        // random patterns, some squeezed into few addresses
        for (int r = 0; r < 150; r++) begin
            logic [AW-1:0] msk;
            msk = (r % 3 == 0) ? AW'(63) : AW'(WORDS - 1);
            for (int l = 0; l < LANES; l++) begin
                ta[l] = AW'($urandom) & msk;
                td[l] = $urandom;
            end
            do_req(bit'($urandom % 2), LANES'($urandom), "R4 R7 random");
        end

        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule